// File: doc/BRIEF.md
# Valid-Gated CIC Decimator

This block reduces the sample rate of a scalar signed stream by an integer factor using a cascade of integrators followed by a cascade of combs, with a differential delay of one. Each input word arrives with a single qualifier bit, and only qualified words count. The integrators accumulate on qualified cycles and hold still otherwise. The decimation phase counts qualified samples rather than clock cycles, so the block follows bursty or slow sample rates without any extra configuration. Once every `RATE` qualified samples, a result passes through the comb cascade. It then leaves the block with its own one-cycle qualifier.

The output keeps full precision. It grows by `STAGES*ceil(log2(RATE))` bits over the input, and all arithmetic wraps in two's complement. The block has two resets with separate reach. The asynchronous active-low `rst_n` returns only the control state to its start: the sample phase and the output-qualifier pipeline. The synchronous `dp_clr` zeroes only the arithmetic state: the integrator and comb registers. An integrating system typically pulses both together at start-up and may clear the arithmetic state alone between bursts.

Top module: `cic_decim_stream`

## Requirements
- R1: While `rst_n` is low and on its release, `out_vld` is 0 and the sample phase is 0, so the first output follows the `RATE`-th qualified input after the release.
- R2: A cycle with `in_vld` = 0 changes no state. Neither its `in_data` value nor its presence alters any later output value or output timing.
- R3: Exactly one output is produced per `RATE` qualified inputs, triggered by the qualified input that completes each group of `RATE`.
- R4: `out_vld` is high exactly `STAGES+1` cycles after the cycle in which the triggering qualified input was presented.
- R5: `out_vld` is a single-cycle pulse, never high in two consecutive cycles.
- R6: Each qualified output equals the sum over j of h[j]·x[n−j], taken modulo 2^ACC_W as a signed value. Here x is the sequence of qualified inputs since the last arithmetic clear, x[n] is the triggering input, and x is zero before the clear. The weights h are the coefficients of (1 + z⁻¹ + … + z^−(RATE−1))^STAGES. ACC_W = DATA_W + STAGES·ceil(log2(RATE)), and results are exact for every input, including the most negative one.
- R7: `dp_clr` high at a clock edge zeroes all integrator and comb state. It takes priority over a qualified sample in the same cycle, whose data is discarded as zero while the phase still counts it. It leaves the phase and `out_vld` timing unchanged.
- R8: `rst_n` does not touch the integrator or comb state. After a control reset at phase 0 with no output pending, outputs continue the R6 sequence over the whole history since the last `dp_clr`.
- R9: When qualified inputs arrive every K cycles, output pulses are spaced exactly K·`RATE` cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state only |
| dp_clr | input | 1 | Synchronous clear of integrator and comb state only |
| in_data | input | DATA_W | Signed input sample |
| in_vld | input | 1 | Qualifies `in_data` in this cycle |
| out_data | output | ACC_W | Signed full-precision output, meaningful only while `out_vld` is high |
| out_vld | output | 1 | One-cycle pulse marking a decimated output |

## Verification
A phase counter that slips shows up as outputs arriving after the wrong number of qualified inputs. The scoreboard catches this at the very next expected pulse, by timing or by value. An integrator that moves on an unqualified cycle, or a comb register that misses a clear, corrupts the next output's value. Because integrator state persists, it then corrupts every later output too, so a single bad accumulation keeps failing checks. A wrong valid pipeline depth moves every pulse off the `STAGES+1` cycle slot, and the first output of the run exposes it.

// File: rtl/cic_pkg.sv
package cic_pkg;

  // Bits added by the integrator cascade: STAGES * ceil(log2(RATE))
  function automatic int cic_growth(input int stages, input int rate);
    return stages * $clog2(rate);
  endfunction

  // Output / accumulator width
  function automatic int cic_acc_width(input int data_w, input int stages, input int rate);
    return data_w + cic_growth(stages, rate);
  endfunction

  // Number of impulse-response taps of the whole filter
  function automatic int cic_taps(input int stages, input int rate);
    return stages * (rate - 1) + 1;
  endfunction

endpackage

// File: rtl/cic_phase_ctr.sv
module cic_phase_ctr #(
  parameter int RATE = 4,
  localparam int PW = (RATE > 2) ? $clog2(RATE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  output logic          fire,
  output logic [PW-1:0] phase
);

  localparam logic [PW-1:0] LAST = PW'(RATE - 1);

  logic at_last;
  assign at_last = (phase == LAST);
  assign fire    = in_vld && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (in_vld)
      phase <= at_last ? '0 : phase + 1'b1;
  end

  // R3: phase never leaves 0..RATE-1
  p_phase_range_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < RATE);

  // R2: unqualified cycles leave the phase alone
  p_phase_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(phase));

  // R3: a qualified sample at the last phase returns the count to zero
  p_phase_wrap_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && int'(phase) == RATE - 1) |=> phase == '0);

endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
  parameter int ACC_W  = 18,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dp_clr,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] x,
  output logic signed [ACC_W-1:0] y
);

  logic signed [ACC_W-1:0] acc [STAGES];
  logic signed [ACC_W-1:0] nxt [STAGES];

  // Unpipelined cascade: every stage sees the freshly updated value of the
  // stage before it, so the chain is a pure 1/(1-z^-1)^STAGES in samples.
  always_comb begin
    for (int s = 0; s < STAGES; s++) begin
      if (s == 0) nxt[s] = acc[s] + x;
      else        nxt[s] = acc[s] + nxt[s-1];
    end
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_acc
    always_ff @(posedge clk) begin
      if (dp_clr)      acc[g] <= '0;
      else if (in_vld) acc[g] <= nxt[g];
    end
  end

  assign y = acc[STAGES-1];

  // R2: no qualified sample, no clear -> the cascade output does not move
  p_integ_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && !dp_clr) |=> $stable(y));

  // R7: the clear empties the first and last stages in the next cycle
  p_integ_clr_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    dp_clr |=> (y == '0 && acc[0] == '0));

endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
  parameter int ACC_W  = 18,
  parameter int STAGES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dp_clr,
  input  logic                    fire,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout,
  output logic                    dout_vld
);

  // Control pipeline: vq[k] marks that comb stage k holds its input this cycle
  logic [STAGES:0] vq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vq <= '0;
    else        vq <= {vq[STAGES-1:0], fire};
  end

  logic signed [ACC_W-1:0] cval [STAGES];
  logic signed [ACC_W-1:0] dly  [STAGES];
  logic signed [ACC_W-1:0] sin  [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_comb
    if (g == 0) begin : g_first
      assign sin[g] = din;
    end else begin : g_next
      assign sin[g] = cval[g-1];
    end

    always_ff @(posedge clk) begin
      if (dp_clr) begin
        cval[g] <= '0;
        dly[g]  <= '0;
      end else if (vq[g]) begin
        cval[g] <= sin[g] - dly[g];
        dly[g]  <= sin[g];
      end
    end
  end

  assign dout     = cval[STAGES-1];
  assign dout_vld = vq[STAGES];

  // R5: output qualifier is a single-cycle pulse
  p_vld_pulse_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |=> !dout_vld);

  // R2: with no firing in flight and no clear, the output word is held
  p_comb_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (vq[STAGES-1:0] == '0 && !dp_clr) |=> $stable(dout));

  // R7: the clear zeroes the comb output next cycle
  p_comb_clr_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    dp_clr |=> dout == '0);

endmodule

// File: rtl/cic_decim_stream.sv
module cic_decim_stream #(
  parameter int DATA_W = 12,
  parameter int RATE   = 4,
  parameter int STAGES = 3,
  localparam int ACC_W = cic_pkg::cic_acc_width(DATA_W, STAGES, RATE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dp_clr,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     in_vld,
  output logic signed [ACC_W-1:0]  out_data,
  output logic                     out_vld
);

  localparam int PW = (RATE > 2) ? $clog2(RATE) : 1;

  // Named internal events for the assertions
  logic                    fire;
  logic [PW-1:0]           phase;
  logic signed [ACC_W-1:0] in_ext;
  logic signed [ACC_W-1:0] integ_out;

  assign in_ext = ACC_W'(in_data);   // sign-extended by signed context

  cic_phase_ctr #(.RATE(RATE)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .fire   (fire),
    .phase  (phase)
  );

  cic_integ_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_integ (
    .clk    (clk),
    .rst_n  (rst_n),
    .dp_clr (dp_clr),
    .in_vld (in_vld),
    .x      (in_ext),
    .y      (integ_out)
  );

  cic_comb_chain #(.ACC_W(ACC_W), .STAGES(STAGES)) u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .dp_clr   (dp_clr),
    .fire     (fire),
    .din      (integ_out),
    .dout     (out_data),
    .dout_vld (out_vld)
  );

  // R3: a decimation event needs a qualified input
  p_fire_needs_vld_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (in_vld && int'(phase) == RATE - 1));

  // R1: no output qualifier in the cycle after a reset release
  p_quiet_after_reset_r1 : assert property (@(posedge clk)
    !rst_n |=> !out_vld);

  initial begin
    p_rate_legal_r3 : assert (RATE >= 2 && STAGES >= 1);
  end

endmodule

// File: tb/cic_decim_stream_bench.sv
`timescale 1ns/1ps
module cic_decim_stream_bench;
  import cic_pkg::*;

  localparam int DATA_W = 12;
  localparam int RATE   = 4;
  localparam int STAGES = 3;
  localparam int ACC_W  = cic_acc_width(DATA_W, STAGES, RATE);
  localparam int HLEN   = cic_taps(STAGES, RATE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp_clr = 1'b1;
  logic signed [DATA_W-1:0] in_data = '0;
  logic in_vld = 1'b0;
  logic signed [ACC_W-1:0] out_data;
  logic out_vld;

  always #2.5 clk = ~clk;   // 200 MHz

  cic_decim_stream #(.DATA_W(DATA_W), .RATE(RATE), .STAGES(STAGES)) u_cic_decim_stream (
    .clk(clk), .rst_n(rst_n), .dp_clr(dp_clr),
    .in_data(in_data), .in_vld(in_vld),
    .out_data(out_data), .out_vld(out_vld)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- reference model ----------------
  longint h [HLEN];
  int hist [$];
  int mphase = 0;
  logic signed [ACC_W-1:0] exp_q [$];
  int due_q [$];

  // Weights as repeated convolution with a box of RATE ones (R6)
  function automatic void build_weights();
    longint t [HLEN];
    for (int i = 0; i < HLEN; i++) h[i] = (i == 0) ? 1 : 0;
    for (int s = 0; s < STAGES; s++) begin
      for (int i = 0; i < HLEN; i++) begin
        t[i] = 0;
        for (int k = 0; k < RATE; k++) if (i - k >= 0) t[i] += h[i-k];
      end
      for (int i = 0; i < HLEN; i++) h[i] = t[i];
    end
  endfunction

  function automatic logic signed [ACC_W-1:0] model_out();
    longint s = 0;
    int n = hist.size() - 1;
    for (int j = 0; j < HLEN; j++)
      if (n - j >= 0) s += h[j] * longint'(hist[n-j]);
    return s[ACC_W-1:0];
  endfunction

  task automatic account(input int x, input bit v);
    if (v) begin
      hist.push_back(x);
      if (mphase == RATE - 1) begin
        exp_q.push_back(model_out());
        due_q.push_back(cyc + STAGES + 1);   // R4
      end
      mphase = (mphase + 1) % RATE;
    end
  endtask

  // ---------------- driver ----------------
  task automatic send(input int x, input bit v);
    @(posedge clk); #1;
    dp_clr = 1'b0; in_vld = v; in_data = DATA_W'(x);
    account(x, v);
  endtask

  task automatic clr(input int x, input bit v);   // R7
    @(posedge clk); #1;
    dp_clr = 1'b1; in_vld = v; in_data = DATA_W'(x);
    hist.delete();
    account(0, v);
  endtask

  task automatic grst(input bit also_clr);         // R1 / R8
    @(posedge clk); #1;
    rst_n = 1'b0; dp_clr = also_clr; in_vld = 1'b0;
    mphase = 0;
    if (also_clr) hist.delete();
    @(posedge clk); #1;
    rst_n = 1'b1; dp_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send($urandom_range(0, 4095) - 2048, 1'b0);
  endtask

  // ---------------- monitor / scoreboard ----------------
  bit prev_vld = 0;
  bit gap_mode = 0;
  int last_out = -1;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_vld = 0;
    end else begin
      if (out_vld) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected output cycle %0d actual %0d expected none", cyc, out_data);
        end else begin
          if (due_q[0] != cyc) begin
            errors++;
            $display("FAIL R4 output cycle actual %0d expected %0d", cyc, due_q[0]);
          end
          checks++;
          if (out_data !== exp_q[0]) begin
            errors++;
            $display("FAIL R6 data actual %0d expected %0d", out_data, exp_q[0]);
          end
          void'(exp_q.pop_front());
          void'(due_q.pop_front());
        end
        if (prev_vld) begin   // R5
          errors++;
          $display("FAIL R5 pulse width actual 2+ expected 1 at cycle %0d", cyc);
        end
        if (gap_mode && last_out >= 0) begin   // R9
          checks++;
          if (cyc - last_out != 2 * RATE) begin
            errors++;
            $display("FAIL R9 spacing actual %0d expected %0d", cyc - last_out, 2 * RATE);
          end
        end
        last_out = cyc;
      end else if (due_q.size() > 0 && due_q[0] == cyc) begin
        checks++; errors++;
        $display("FAIL R4 missing output at cycle %0d actual 0 expected 1", cyc);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
      end
      prev_vld = out_vld;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    build_weights();
    repeat (3) @(posedge clk);
    #1;
    // R1: quiet during reset
    checks++;
    if (out_vld !== 1'b0) begin errors++; $display("FAIL R1 out_vld in reset actual %b expected 0", out_vld); end
    rst_n = 1'b1; dp_clr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (out_vld !== 1'b0) begin errors++; $display("FAIL R1 out_vld after reset actual %b expected 0", out_vld); end
    end

    // R3 R4 R6: dense ramp
    for (int i = 0; i < 24; i++) send(i * 37 - 300, 1'b1);
    idle(10);

    // R9 R2: qualified every second cycle, junk on the other cycles
    gap_mode = 1; last_out = -1;
    for (int i = 0; i < 32; i++) begin
      send($urandom_range(0, 4095) - 2048, 1'b1);
      send($urandom_range(0, 4095) - 2048, 1'b0);
    end
    idle(8);
    gap_mode = 0;

    // R2 R6: random gaps and data (80 qualified samples)
    for (int i = 0; i < 80; i++) begin
      send($urandom_range(0, 4095) - 2048, 1'b1);
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    idle(8);

    // R6 R7: clear at phase 0, then full-scale extremes
    clr(0, 1'b0);
    for (int i = 0; i < 16; i++) send(2047, 1'b1);
    for (int i = 0; i < 16; i++) send(-2048, 1'b1);
    idle(8);

    // R7: clear coinciding with a qualified sample (discarded, still counted)
    clr(1500, 1'b1);
    for (int i = 0; i < 11; i++) send(100 + 50 * i, 1'b1);
    idle(8);

    // R8: control reset at phase 0, history kept
    grst(1'b0);
    for (int i = 0; i < 12; i++) send(-700 + 123 * i, 1'b1);
    idle(8);

    // R1: control reset in mid phase (with clear), count restarts
    send(900, 1'b1);
    send(-400, 1'b1);
    idle(8);
    grst(1'b1);
    for (int i = 0; i < 12; i++) send(333 - 61 * i, 1'b1);
    idle(12);

    // R3: nothing left pending
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 pending outputs actual %0d expected 0", exp_q.size());
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule